// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a two-part logical address into a physical address. The two parts are a segment number and an offset inside that segment. The per-segment description lives in a table held in external memory. Two configuration inputs locate that table: the address where it starts and the number of segments the running program owns. For each request the unit fetches the two-word entry of the addressed segment through a simple read port. It then checks the entry against the request and returns either the relocated address or a fault code that names the first rule the request broke.

A request is taken when `req_valid` is high while `req_ready` is high. The unit works on one translation at a time. The result appears together with a one-cycle `rsp_done` pulse and is held until the next result. The memory read port keeps `mem_rd_en` and `mem_rd_addr` steady until `mem_rd_valid` returns the data word in that same cycle. Any read latency is therefore tolerated.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset `rsp_done` and `mem_rd_en` are low, `req_ready` is high, and `rsp_fault` and `rsp_paddr` are zero.
- R2: A segment number not strictly below `tbl_len` ends with fault code 1 and performs no memory read.
- R3: A legal segment number causes exactly two reads, in this order. The first read is at `tbl_base + 8*seg` and returns word 0, which carries the segment base in bits 23:0. The second read is at that address plus 4 and returns word 1. Each address stays stable until its `mem_rd_valid`.
- R4: When bit 31 of word 1 (the valid flag) is 0, the result is fault code 2. This fault outranks the limit check and the permission check.
- R5: An offset greater than or equal to the limit in bits 15:0 of word 1 gives fault code 3. This fault outranks the permission check.
- R6: Access code 0 (read) needs bit 30 of word 1, code 1 (write) needs bit 29, and code 2 (fetch) needs bit 28. A missing permission gives fault code 4. Code 3 always gives fault code 4.
- R7: When every check passes, fault code 0 is returned and `rsp_paddr` equals base plus offset, taken modulo 2^24.
- R8: `rsp_done` is high for exactly one cycle. `req_ready` is low from acceptance through the done cycle and high again in the cycle after it.
- R9: Whenever a non-zero fault code is reported, `rsp_paddr` is zero.
- R10: The range check follows the live `tbl_len`. Segment `tbl_len-1` is legal, and `tbl_len` of 0 rejects every segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 32 | Byte address of the segment table |
| tbl_len | input | 9 | Number of segments in use |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_seg | input | 8 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| mem_rd_en | output | 1 | Table read request, held until answered |
| mem_rd_addr | output | 32 | Table read byte address |
| mem_rd_valid | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Read data word |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_fault | output | 3 | Fault code, 0 when translation succeeded |
| rsp_paddr | output | 24 | Physical address, zero on a fault |

## Verification
The hardest cases to reach are the ones where several checks fail at once. These need entries that are both invalid and too short, or both too short and lacking permission, so the fault priority can be seen. The bench builds a table with such entries on purpose and sends offsets that break more than one rule. A second source of difficulty is the read-hold behaviour, which only shows under a slow memory. The same vectors are therefore run again with a memory model whose answer latency is raised to several cycles.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_PRIV    = 3'd4
  } xl_fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } xl_acc_e;

  // attribute word layout
  localparam int ATTR_VALID_BIT = 31;
  localparam int ATTR_RD_BIT    = 30;
  localparam int ATTR_WR_BIT    = 29;
  localparam int ATTR_EX_BIT    = 28;

  // table entry geometry
  localparam int ENTRY_SHIFT = 3;
  localparam int WORD_BYTES  = 4;

endpackage

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int PA_W  = 24
) (
  input  logic [PA_W-1:0]  seg_base,
  input  logic             attr_valid,
  input  logic [2:0]       attr_rwx,
  input  logic [OFF_W-1:0] seg_limit,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       acc,
  output xl_fault_e        fault,
  output logic [PA_W-1:0]  paddr
);

  localparam int PAD_W = PA_W - OFF_W;

  logic allowed;

  always_comb begin
    case (xl_acc_e'(acc))
      ACC_READ:  allowed = attr_rwx[2];
      ACC_WRITE: allowed = attr_rwx[1];
      ACC_FETCH: allowed = attr_rwx[0];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!attr_valid)             fault = FLT_INVALID;
    else if (off >= seg_limit)   fault = FLT_LIMIT;
    else if (!allowed)           fault = FLT_PRIV;
    else                         fault = FLT_NONE;
  end

  always_comb begin
    if (fault == FLT_NONE) paddr = seg_base + {{PAD_W{1'b0}}, off};
    else                   paddr = '0;
  end

endmodule

// File: rtl/seg_xlate_seq.sv
module seg_xlate_seq
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    tbl_base,
  input  logic [SEG_W:0]   tbl_len,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [DW-1:0]    mem_rd_data,
  output logic             range_reject,
  output logic             attr_take,
  output logic             in_done,
  output logic [PA_W-1:0]  base_q,
  output logic [OFF_W-1:0] off_q,
  output logic [1:0]       acc_q
);

  typedef enum logic [1:0] {S_IDLE, S_BASE, S_ATTR, S_DONE} seq_state_e;

  localparam int SEG_PAD = AW - SEG_W;

  seq_state_e state_q, state_d;
  logic       accept, seg_legal;
  logic [AW-1:0] addr_q, addr_d;
  logic       addr_en, base_en;

  assign accept    = (state_q == S_IDLE) && req_valid;
  assign seg_legal = {1'b0, req_seg} < tbl_len;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (accept) state_d = seg_legal ? S_BASE : S_DONE;
      S_BASE:  if (mem_rd_valid) state_d = S_ATTR;
      S_ATTR:  if (mem_rd_valid) state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  assign addr_en = accept || ((state_q == S_BASE) && mem_rd_valid);
  assign base_en = (state_q == S_BASE) && mem_rd_valid;

  always_comb begin
    if (state_q == S_IDLE)
      addr_d = tbl_base + ({{SEG_PAD{1'b0}}, req_seg} << ENTRY_SHIFT);
    else
      addr_d = addr_q + AW'(WORD_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= mem_rd_data[PA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      acc_q <= '0;
    end else if (accept) begin
      off_q <= req_off;
      acc_q <= req_acc;
    end
  end

  assign req_ready    = (state_q == S_IDLE);
  assign mem_rd_en    = (state_q == S_BASE) || (state_q == S_ATTR);
  assign mem_rd_addr  = addr_q;
  assign range_reject = accept && !seg_legal;
  assign attr_take    = (state_q == S_ATTR) && mem_rd_valid;
  assign in_done      = (state_q == S_DONE);

  // R2
  no_read_on_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_reject |=> !mem_rd_en);

  // R3
  second_read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_BASE) && mem_rd_valid) |=> mem_rd_en && (mem_rd_addr == $past(mem_rd_addr) + AW'(WORD_BYTES)));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> mem_rd_en && $stable(mem_rd_addr));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    tbl_base,
  input  logic [SEG_W:0]   tbl_len,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [DW-1:0]    mem_rd_data,
  output logic             rsp_done,
  output logic [2:0]       rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);

  logic             range_reject, attr_take, in_done;
  logic [PA_W-1:0]  base_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       acc_q;
  xl_fault_e        chk_fault;
  logic [PA_W-1:0]  chk_paddr;

  logic [2:0]       fault_q, fault_d;
  logic [PA_W-1:0]  paddr_q, paddr_d;
  logic             rsp_en;

  seg_xlate_seq #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .AW(AW), .DW(DW)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tbl_base     (tbl_base),
    .tbl_len      (tbl_len),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_seg      (req_seg),
    .req_off      (req_off),
    .req_acc      (req_acc),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .range_reject (range_reject),
    .attr_take    (attr_take),
    .in_done      (in_done),
    .base_q       (base_q),
    .off_q        (off_q),
    .acc_q        (acc_q)
  );

  seg_xlate_check #(
    .OFF_W(OFF_W), .PA_W(PA_W)
  ) u_check (
    .seg_base   (base_q),
    .attr_valid (mem_rd_data[ATTR_VALID_BIT]),
    .attr_rwx   ({mem_rd_data[ATTR_RD_BIT], mem_rd_data[ATTR_WR_BIT], mem_rd_data[ATTR_EX_BIT]}),
    .seg_limit  (mem_rd_data[OFF_W-1:0]),
    .off        (off_q),
    .acc        (acc_q),
    .fault      (chk_fault),
    .paddr      (chk_paddr)
  );

  assign rsp_en = range_reject || attr_take;

  always_comb begin
    if (range_reject) begin
      fault_d = FLT_RANGE;
      paddr_d = '0;
    end else begin
      fault_d = chk_fault;
      paddr_d = chk_paddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
      paddr_q <= '0;
    end else if (rsp_en) begin
      fault_q <= fault_d;
      paddr_q <= paddr_d;
    end
  end

  assign rsp_done  = in_done;
  assign rsp_fault = fault_q;
  assign rsp_paddr = paddr_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done && req_ready);

  // R9
  fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && (rsp_fault != 3'd0)) |-> (rsp_paddr == '0));

  // R2
  range_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_reject |=> rsp_done && (rsp_fault == 3'd1));

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;

  localparam logic [31:0] TBL_BASE = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] tbl_base;
  logic [8:0]  tbl_len;
  logic        req_valid, req_ready;
  logic [7:0]  req_seg;
  logic [15:0] req_off;
  logic [1:0]  req_acc;
  logic        mem_rd_en, mem_rd_valid;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        rsp_done;
  logic [2:0]  rsp_fault;
  logic [23:0] rsp_paddr;

  int n_checks = 0;
  int n_fail   = 0;
  int lat      = 0;
  int wait_cnt = 0;
  int rd_total = 0;
  logic [31:0] rd_prev, rd_last;
  logic [31:0] mem [0:511];

  always #5 clk = ~clk;

  seg_xlate_unit i_seg_xlate_unit (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_len(tbl_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
    .req_off(req_off), .req_acc(req_acc), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr)
  );

  // memory model: answers after lat extra cycles, one-cycle valid
  always_ff @(posedge clk) begin
    if (mem_rd_en && !mem_rd_valid) begin
      if (wait_cnt >= lat) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem[mem_rd_addr[10:2]];
        wait_cnt     <= 0;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      mem_rd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_rd_en && mem_rd_valid) begin
      rd_total <= rd_total + 1;
      rd_prev  <= rd_last;
      rd_last  <= mem_rd_addr;
    end
  end

  function automatic logic [31:0] attr(input bit v, input logic [2:0] rwx, input logic [15:0] lim);
    return {v, rwx, 12'h000, lim};
  endfunction

  task automatic chk(input bit ok, input string what, input int rq, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]  seg;
    logic [15:0] off;
    logic [1:0]  acc;
    logic [2:0]  flt;
    logic [23:0] pa;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'd0, 16'h0000, 2'd0, 3'd0, 24'h001000, 4'd7},  // R7 plain read
    '{8'd0, 16'h00FF, 2'd1, 3'd0, 24'h0010FF, 4'd5},  // R5 last offset inside
    '{8'd0, 16'h0100, 2'd2, 3'd3, 24'h000000, 4'd5},  // R5 offset equals limit
    '{8'd1, 16'h000F, 2'd0, 3'd0, 24'h02000F, 4'd6},  // R6 read allowed
    '{8'd1, 16'h0005, 2'd1, 3'd4, 24'h000000, 4'd6},  // R6 write denied
    '{8'd1, 16'h0005, 2'd2, 3'd4, 24'h000000, 4'd6},  // R6 fetch denied
    '{8'd1, 16'h0020, 2'd1, 3'd3, 24'h000000, 4'd5},  // R5 limit before rights
    '{8'd2, 16'h0000, 2'd0, 3'd2, 24'h000000, 4'd4},  // R4 invalid entry
    '{8'd3, 16'h0200, 2'd1, 3'd0, 24'h000100, 4'd7},  // R7 wraps mod 2^24
    '{8'd3, 16'h0200, 2'd0, 3'd4, 24'h000000, 4'd6},  // R6 read denied
    '{8'd3, 16'h0010, 2'd3, 3'd4, 24'h000000, 4'd6},  // R6 reserved code
    '{8'd4, 16'h0000, 2'd0, 3'd3, 24'h000000, 4'd5},  // R5 zero limit
    '{8'd5, 16'h2000, 2'd1, 3'd2, 24'h000000, 4'd4},  // R4 invalid outranks limit
    '{8'd6, 16'h0000, 2'd0, 3'd1, 24'h000000, 4'd10}, // R10 seg equals len
    '{8'hFF, 16'h0000, 2'd0, 3'd1, 24'h000000, 4'd2}, // R2 far out of range
    '{8'd3, 16'hFFFE, 2'd2, 3'd0, 24'h00FEFE, 4'd7}   // R7 fetch near limit
  };

  task automatic run(input vec_t v);
    int start, cyc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    start     = rd_total;
    req_valid = 1'b1;
    req_seg   = v.seg;
    req_off   = v.off;
    req_acc   = v.acc;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(rsp_done, "done seen", 8, rsp_done, 1);
    chk(rsp_fault == v.flt, "fault code", int'(v.rq), rsp_fault, v.flt);
    chk(rsp_paddr == v.pa, "phys addr", (v.flt != 0) ? 9 : int'(v.rq), rsp_paddr, v.pa);
    chk(!req_ready, "ready low at done", 8, req_ready, 0);
    if (v.flt == 3'd1) begin
      chk(rd_total == start, "no read on range fault", 2, rd_total - start, 0);
    end else begin
      chk(rd_total == start + 2, "read count", 3, rd_total - start, 2);
      chk(rd_prev == TBL_BASE + 32'(v.seg) * 8, "first read addr", 3, rd_prev, TBL_BASE + 32'(v.seg) * 8);
      chk(rd_last == TBL_BASE + 32'(v.seg) * 8 + 4, "second read addr", 3, rd_last, TBL_BASE + 32'(v.seg) * 8 + 4);
    end
    @(negedge clk);
    chk(!rsp_done, "done one cycle", 8, rsp_done, 0);
    chk(req_ready, "ready after done", 8, req_ready, 1);
  endtask

  initial begin
    #(10 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    // table entries: word0 base, word1 attributes
    mem[(TBL_BASE >> 2) + 0]  = 32'h0000_1000; mem[(TBL_BASE >> 2) + 1]  = attr(1, 3'b111, 16'h0100);
    mem[(TBL_BASE >> 2) + 2]  = 32'h0002_0000; mem[(TBL_BASE >> 2) + 3]  = attr(1, 3'b100, 16'h0010);
    mem[(TBL_BASE >> 2) + 4]  = 32'h0003_00F0; mem[(TBL_BASE >> 2) + 5]  = attr(0, 3'b111, 16'h8000);
    mem[(TBL_BASE >> 2) + 6]  = 32'h00FF_FF00; mem[(TBL_BASE >> 2) + 7]  = attr(1, 3'b011, 16'hFFFF);
    mem[(TBL_BASE >> 2) + 8]  = 32'h0005_0000; mem[(TBL_BASE >> 2) + 9]  = attr(1, 3'b111, 16'h0000);
    mem[(TBL_BASE >> 2) + 10] = 32'h0006_0000; mem[(TBL_BASE >> 2) + 11] = attr(0, 3'b000, 16'h1000);
    mem_rd_valid = 1'b0;
    mem_rd_data  = '0;
    rd_prev = '0;
    rd_last = '0;
    tbl_base  = TBL_BASE;
    tbl_len   = 9'd6;
    req_valid = 1'b0;
    req_seg   = '0;
    req_off   = '0;
    req_acc   = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rsp_done, "reset done", 1, rsp_done, 0);
    chk(req_ready, "reset ready", 1, req_ready, 1);
    chk(!mem_rd_en, "reset rd_en", 1, mem_rd_en, 0);
    chk(rsp_fault == 0 && rsp_paddr == 0, "reset outputs", 1, {rsp_fault, rsp_paddr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run(VECS[i]);

    // slow memory: R3 address hold under stall
    lat = 3;
    run(VECS[0]);
    run(VECS[8]);
    run(VECS[12]);
    lat = 0;

    // R10 length register of zero rejects segment 0
    tbl_len = 9'd0;
    run('{8'd0, 16'h0000, 2'd0, 3'd1, 24'h000000, 4'd10});
    // R10 last legal segment with narrowed length
    tbl_len = 9'd4;
    run('{8'd3, 16'h0200, 2'd1, 3'd0, 24'h000100, 4'd10});
    run('{8'd4, 16'h0000, 2'd0, 3'd1, 24'h000000, 4'd10});

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule